// File: doc/BRIEF.md
# Key-Protected Sequence Table

This block stores 16 instruction sequences of four 32-bit words each, for a serial-memory controller. A sequence engine elsewhere reads a whole sequence at once through a dedicated port, and a host reaches every word through a simple strobe-based register write and read interface. The block does not decode or execute the instructions it holds.

Table writes from the host are guarded by a lock. To change the lock state, the host first writes a fixed 32-bit key to a key register and then writes a command to a lock-control register. A command that does not follow a correct key write is ignored. While the table is locked, host writes to table words are discarded. Reads still work. Sequence 0 leaves reset holding a preset single-lane read sequence, so the engine has something valid to fetch before any software runs.

Top module: `keyed_seq_table`

## Requirements
- R1: During and right after reset, `locked` is 1. Word 0 of sequence 0 is 0x08180403, word 1 of sequence 0 is 0x00001C00, and every other table word is 0. The preset encodes, in 16-bit slots taken low slot first: command 0x03, 24-bit address, data read, stop.
- R2: Word k of sequence s sits at byte address 0x100 + s*16 + k*4. A host read (`rd_en`) returns that word on `rd_data` one cycle later. Writes to addresses outside 0x100..0x1FF never change the table.
- R3: A write of 0x5AF05AF0 to address 0x000, followed by a write to address 0x004 with bits [1:0] = 2'b10, clears `locked` in the cycle after the command write.
- R4: The key write followed by a command write with bits [1:0] = 2'b01 sets `locked`.
- R5: While `locked` is 1, host writes to table words are dropped, and reads return the stored contents.
- R6: While `locked` is 0, a host write to a table word is stored and can be read back.
- R7: A write to 0x004 that is not immediately preceded, among host writes, by a correct key write leaves the lock state unchanged.
- R8: A command write with bits [1:0] equal to 2'b00 or 2'b11 leaves the lock state unchanged and uses up the key.
- R9: Any host write other than the command write, including a key write with a wrong value or a table write, cancels a pending key. Idle cycles and reads do not cancel it.
- R10: One cycle after `eng_sel` selects sequence s, `eng_words` holds its four words, with word k at bits [32k+31:32k].
- R11: A host read of 0x004 returns the lock state in bit 0 with the other bits at 0. A read of 0x000 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 12 | Host write byte address |
| wr_data | input | 32 | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 12 | Host read byte address |
| rd_data | output | 32 | Host read data, one cycle after `rd_en` |
| eng_sel | input | 4 | Sequence index requested by the engine |
| eng_words | output | 128 | Four words of the selected sequence, registered |
| locked | output | 1 | Current lock state |

## Verification
The bench targets the ways the key handshake can be bypassed. It issues a command with no key, a wrong key value, a table write between the key and the command, a reused key after a no-op command, and a read between the key and the command. A design that kept the key armed too long would unlock in some of these cases. A design that cleared it on reads would stay locked where it should not. The bench also checks that table writes landing while the table is locked leave the old data intact, that a write just past the table's end does not alias into sequence 0, and that a reset in mid-run restores the preset and clears user sequences.

// File: rtl/keyed_seq_pkg.sv
// Package: constants shared by the sequence table blocks.
// Assumes 32-bit table words made of two 16-bit instruction slots,
// slot = {opcode[5:0], lanes[1:0], operand[7:0]}, low slot executed first.
package keyed_seq_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam logic [31:0] KEY_VALUE = 32'h5AF0_5AF0;

    localparam logic [5:0] OP_STOP = 6'd0;
    localparam logic [5:0] OP_CMD  = 6'd1;
    localparam logic [5:0] OP_ADDR = 6'd2;
    localparam logic [5:0] OP_READ = 6'd7;

    // Build one 16-bit instruction slot.
    function automatic logic [15:0] slot(input logic [5:0] op, input logic [1:0] lanes,
                                         input logic [7:0] operand);
        return {op, lanes, operand};
    endfunction

    // Reset contents of flat word index idx: a preset read in sequence 0.
    function automatic logic [WORD_W-1:0] preload_word(input int unsigned idx);
        case (idx)
            0:       return {slot(OP_ADDR, 2'd0, 8'd24), slot(OP_CMD, 2'd0, 8'h03)};
            1:       return {slot(OP_STOP, 2'd0, 8'd0),  slot(OP_READ, 2'd0, 8'd0)};
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/seq_key_lock.sv
// Module: seq_key_lock
// Tracks the two-write handshake that moves the table between locked and
// unlocked. A correct key write arms the handshake; the very next host write
// is either the command (consumes the arming) or anything else (cancels it).
// Assumes one host write per cycle at most; reads never reach this module.
module seq_key_lock
    import keyed_seq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned KEY_ADDR  = 'h000,
    parameter int unsigned CTRL_ADDR = 'h004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic              locked,
    output logic              armed
);
    localparam logic [ADDR_W-1:0] KEY_A  = ADDR_W'(KEY_ADDR);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic key_hit;
    logic ctrl_hit;

    // Classify the current host write.
    always_comb begin
        key_hit  = wr_en && (wr_addr == KEY_A) && (wr_data == KEY_VALUE);
        ctrl_hit = wr_en && (wr_addr == CTRL_A);
    end

    // Arming flag: set by a good key, cleared by any other host write.
    always_ff @(posedge clk) begin
        if (!rst_n)      armed <= 1'b0;
        else if (wr_en)  armed <= key_hit;
    end

    // Lock state: only an armed command with exactly one request bit acts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b1;
        end else if (ctrl_hit && armed) begin
            case (wr_data[1:0])
                2'b01:   locked <= 1'b1;
                2'b10:   locked <= 1'b0;
                default: locked <= locked;
            endcase
        end
    end
endmodule

// File: rtl/seq_table_store.sv
// Module: seq_table_store
// Word storage for all sequences with one host write port, one registered
// host read port and a registered whole-sequence port for the engine.
// Assumes the caller has already decided whether a write is allowed.
// A read in the same cycle as a write to the same word returns the old value.
module seq_table_store
    import keyed_seq_pkg::*;
#(
    parameter int unsigned NUM_SEQ       = 16,
    parameter int unsigned WORDS_PER_SEQ = 4,
    localparam int unsigned DEPTH        = NUM_SEQ * WORDS_PER_SEQ,
    localparam int unsigned IDX_W        = $clog2(DEPTH),
    localparam int unsigned SEQ_W        = $clog2(NUM_SEQ)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [IDX_W-1:0]                widx,
    input  logic [WORD_W-1:0]               wdata,
    input  logic                            re,
    input  logic [IDX_W-1:0]                ridx,
    output logic [WORD_W-1:0]               rdata,
    input  logic [SEQ_W-1:0]                eng_sel,
    output logic [WORDS_PER_SEQ*WORD_W-1:0] eng_words
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Storage: preset on reset, otherwise accept granted host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= preload_word(i);
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    // Host read register, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[ridx];
    end

    // Engine port: one register lane per word of the selected sequence.
    for (genvar k = 0; k < WORDS_PER_SEQ; k++) begin : g_eng
        logic [IDX_W-1:0] eidx;
        always_comb eidx = IDX_W'(eng_sel * WORDS_PER_SEQ + k);
        // Capture word k of the selected sequence.
        always_ff @(posedge clk) begin
            if (!rst_n) eng_words[k*WORD_W +: WORD_W] <= '0;
            else        eng_words[k*WORD_W +: WORD_W] <= mem[eidx];
        end
    end
endmodule

// File: rtl/keyed_seq_table.sv
// Module: keyed_seq_table
// Top level: decodes host addresses into key, lock-control and table
// windows, grants table writes only while unlocked, and merges read data.
// Assumes TABLE_BASE + table size fits in the address space and that
// the key and control addresses lie outside the table window.
module keyed_seq_table
    import keyed_seq_pkg::*;
#(
    parameter int unsigned ADDR_W        = 12,
    parameter int unsigned NUM_SEQ       = 16,
    parameter int unsigned WORDS_PER_SEQ = 4,
    parameter int unsigned KEY_ADDR      = 'h000,
    parameter int unsigned CTRL_ADDR     = 'h004,
    parameter int unsigned TABLE_BASE    = 'h100,
    localparam int unsigned DEPTH        = NUM_SEQ * WORDS_PER_SEQ,
    localparam int unsigned IDX_W        = $clog2(DEPTH),
    localparam int unsigned SEQ_W        = $clog2(NUM_SEQ),
    localparam int unsigned SPAN         = DEPTH * 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [31:0]                     wr_data,
    input  logic                            rd_en,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [31:0]                     rd_data,
    input  logic [SEQ_W-1:0]                eng_sel,
    output logic [WORDS_PER_SEQ*WORD_W-1:0] eng_words,
    output logic                            locked
);
    typedef enum logic [1:0] {RD_NONE, RD_TABLE, RD_CTRL} rd_kind_e;

    logic              key_armed;
    logic [ADDR_W-1:0] woff, roff;
    logic              w_in_tbl, r_in_tbl;
    logic              tbl_we;
    logic [IDX_W-1:0]  widx, ridx;
    logic [31:0]       tbl_rdata;
    rd_kind_e          rd_kind_q;
    logic              lock_snap_q;

    seq_key_lock #(
        .ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR), .CTRL_ADDR(CTRL_ADDR)
    ) u_lock (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .locked(locked), .armed(key_armed)
    );

    // Table window decode for both ports; addresses below base wrap high.
    always_comb begin
        woff     = wr_addr - ADDR_W'(TABLE_BASE);
        roff     = rd_addr - ADDR_W'(TABLE_BASE);
        w_in_tbl = woff < ADDR_W'(SPAN);
        r_in_tbl = roff < ADDR_W'(SPAN);
        widx     = IDX_W'(woff >> 2);
        ridx     = IDX_W'(roff >> 2);
        tbl_we   = wr_en && w_in_tbl && !locked;
    end

    seq_table_store #(
        .NUM_SEQ(NUM_SEQ), .WORDS_PER_SEQ(WORDS_PER_SEQ)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(widx), .wdata(wr_data),
        .re(rd_en && r_in_tbl), .ridx(ridx), .rdata(tbl_rdata),
        .eng_sel(eng_sel), .eng_words(eng_words)
    );

    // Remember what the last read targeted, plus the lock bit it saw.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_kind_q   <= RD_NONE;
            lock_snap_q <= 1'b1;
        end else if (rd_en) begin
            lock_snap_q <= locked;
            if (r_in_tbl)                          rd_kind_q <= RD_TABLE;
            else if (rd_addr == ADDR_W'(CTRL_ADDR)) rd_kind_q <= RD_CTRL;
            else                                   rd_kind_q <= RD_NONE;
        end
    end

    // Read data merge.
    always_comb begin
        case (rd_kind_q)
            RD_TABLE: rd_data = tbl_rdata;
            RD_CTRL:  rd_data = {31'd0, lock_snap_q};
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/keyed_seq_table_chk.sv
// Module: keyed_seq_table_chk
// Protocol checker for the lock handshake, bound into keyed_seq_table.
// Assumes it sees the top's host write port, lock output and arming flag.
module keyed_seq_table_chk
    import keyed_seq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned KEY_ADDR  = 'h000,
    parameter int unsigned CTRL_ADDR = 'h004
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              locked,
    input logic              armed
);
    localparam logic [ADDR_W-1:0] KEY_A  = ADDR_W'(KEY_ADDR);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    assert_reset_locked_R1: assert property (@(posedge clk)
        !rst_n |=> locked);

    assert_unlock_needs_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(locked)) |->
            $past(wr_en && wr_addr == CTRL_A && wr_data[1:0] == 2'b10 && armed));

    assert_lock_needs_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(locked)) |->
            $past(wr_en && wr_addr == CTRL_A && wr_data[1:0] == 2'b01 && armed));

    assert_unkeyed_cmd_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CTRL_A && !armed) |=> $stable(locked));

    assert_noop_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CTRL_A && (wr_data[1:0] == 2'b00 || wr_data[1:0] == 2'b11))
            |=> ($stable(locked) && !armed));

    assert_arm_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(armed)) |-> $past(wr_en && wr_addr == KEY_A && wr_data == KEY_VALUE));

    assert_other_write_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(wr_addr == KEY_A && wr_data == KEY_VALUE)) |=> !armed);
endmodule

bind keyed_seq_table keyed_seq_table_chk #(
    .ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .locked(locked), .armed(key_armed)
);

// File: tb/sim_keyed_seq_table.sv
// Bench for keyed_seq_table: a vector table walk, then directed tests.
module sim_keyed_seq_table;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [11:0]  wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic         rd_en = 1'b0;
    logic [11:0]  rd_addr = '0;
    logic [31:0]  rd_data;
    logic [3:0]   eng_sel = '0;
    logic [127:0] eng_words;
    logic         locked;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    always #2.5 clk = ~clk;

    keyed_seq_table u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .eng_sel(eng_sel), .eng_words(eng_words), .locked(locked)
    );

    localparam logic [31:0] KEY = 32'h5AF0_5AF0;

    // {op(2): 0 write / 1 read-check, req(4), addr(12), data(32), expected(32)}
    localparam int NV = 36;
    localparam logic [81:0] VEC [NV] = '{
        {2'd0, 4'd3,  12'h000, KEY,           32'h0},          // R3 key
        {2'd0, 4'd3,  12'h004, 32'h2,         32'h0},          // R3 unlock
        {2'd1, 4'd3,  12'h004, 32'h0,         32'h0},          // R3 now unlocked
        {2'd0, 4'd6,  12'h110, 32'h1111_1111, 32'h0},
        {2'd1, 4'd6,  12'h110, 32'h0,         32'h1111_1111},  // R6 stored
        {2'd0, 4'd2,  12'h13C, 32'hCAFE_0003, 32'h0},
        {2'd1, 4'd2,  12'h13C, 32'h0,         32'hCAFE_0003},  // R2 seq3 word3
        {2'd0, 4'd4,  12'h000, KEY,           32'h0},
        {2'd0, 4'd4,  12'h004, 32'h1,         32'h0},
        {2'd1, 4'd4,  12'h004, 32'h0,         32'h1},          // R4 locked
        {2'd0, 4'd5,  12'h110, 32'h0000_DEAD, 32'h0},
        {2'd1, 4'd5,  12'h110, 32'h0,         32'h1111_1111},  // R5 dropped
        {2'd0, 4'd7,  12'h004, 32'h2,         32'h0},
        {2'd1, 4'd7,  12'h004, 32'h0,         32'h1},          // R7 no key
        {2'd0, 4'd9,  12'h000, KEY,           32'h0},
        {2'd0, 4'd9,  12'h120, 32'h1234_5678, 32'h0},
        {2'd0, 4'd9,  12'h004, 32'h2,         32'h0},
        {2'd1, 4'd9,  12'h004, 32'h0,         32'h1},          // R9 table write disarms
        {2'd1, 4'd5,  12'h120, 32'h0,         32'h0},          // R5 locked write dropped
        {2'd0, 4'd9,  12'h000, 32'h5AF0_5AF1, 32'h0},
        {2'd0, 4'd9,  12'h004, 32'h2,         32'h0},
        {2'd1, 4'd9,  12'h004, 32'h0,         32'h1},          // R9 wrong key
        {2'd0, 4'd8,  12'h000, KEY,           32'h0},
        {2'd0, 4'd8,  12'h004, 32'h3,         32'h0},
        {2'd1, 4'd8,  12'h004, 32'h0,         32'h1},          // R8 both bits
        {2'd0, 4'd8,  12'h004, 32'h2,         32'h0},
        {2'd1, 4'd8,  12'h004, 32'h0,         32'h1},          // R8 key used up
        {2'd0, 4'd8,  12'h000, KEY,           32'h0},
        {2'd0, 4'd8,  12'h004, 32'h0,         32'h0},
        {2'd0, 4'd8,  12'h004, 32'h2,         32'h0},
        {2'd1, 4'd8,  12'h004, 32'h0,         32'h1},          // R8 no bits
        {2'd0, 4'd11, 12'h000, KEY,           32'h0},
        {2'd1, 4'd11, 12'h004, 32'h0,         32'h1},          // R11 read keeps key
        {2'd0, 4'd9,  12'h004, 32'h2,         32'h0},
        {2'd1, 4'd9,  12'h004, 32'h0,         32'h0},          // R9 read did not disarm
        {2'd1, 4'd11, 12'h000, 32'h0,         32'h0}           // R11 key reads 0
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic engine(input logic [3:0] s, input logic [127:0] exp);
        @(negedge clk);
        eng_sel = s;
        @(negedge clk);
        check("R10 engine words", eng_words, exp);
    endtask

    initial begin
        logic [31:0] d;
        do_reset();
        // R1 reset state
        check("R1 locked after reset", {127'd0, locked}, 128'd1);
        do_read(12'h100, d); check("R1 seq0 word0", {96'd0, d}, {96'd0, 32'h0818_0403});
        do_read(12'h104, d); check("R1 seq0 word1", {96'd0, d}, {96'd0, 32'h0000_1C00});
        do_read(12'h108, d); check("R1 seq0 word2", {96'd0, d}, 128'd0);
        do_read(12'h1FC, d); check("R1 seq15 word3", {96'd0, d}, 128'd0);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            logic [81:0] v;
            v = VEC[i];
            if (v[81:80] == 2'd0) begin
                do_write(v[75:64], v[63:32]);
            end else begin
                do_read(v[75:64], d);
                n_checks++;
                if (d !== v[31:0]) begin
                    n_fail++;
                    $display("FAIL R%0d vector %0d: actual %h expected %h",
                             v[79:76], i, d, v[31:0]);
                end
            end
        end
        check("R3 locked port low", {127'd0, locked}, 128'd0);

        // R10 engine port
        engine(4'd0, {32'd0, 32'd0, 32'h0000_1C00, 32'h0818_0403});
        engine(4'd3, {32'hCAFE_0003, 32'd0, 32'd0, 32'd0});
        engine(4'd1, {32'd0, 32'd0, 32'd0, 32'h1111_1111});

        // R2 boundary: last word, and a write just past the table
        do_write(12'h1FC, 32'hF00D_000F);
        do_read(12'h1FC, d); check("R2 last word", {96'd0, d}, {96'd0, 32'hF00D_000F});
        do_write(12'h200, 32'hBAD0_BAD0);
        do_read(12'h100, d); check("R2 no alias past end", {96'd0, d}, {96'd0, 32'h0818_0403});
        do_write(12'h0FC, 32'hBAD1_BAD1);
        do_read(12'h1FC, d); check("R2 no alias below base", {96'd0, d}, {96'd0, 32'hF00D_000F});

        // R1 mid-run reset restores preset and clears user words
        do_reset();
        check("R1 relocked after reset", {127'd0, locked}, 128'd1);
        do_read(12'h110, d); check("R1 seq1 cleared", {96'd0, d}, 128'd0);
        do_read(12'h13C, d); check("R1 seq3 cleared", {96'd0, d}, 128'd0);
        do_read(12'h104, d); check("R1 preset back", {96'd0, d}, {96'd0, 32'h0000_1C00});
        do_read(12'h004, d); check("R11 ctrl reads locked", {96'd0, d}, 128'd1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(5 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule